// File: doc/BRIEF.md
# Start-Gap Wear-Leveling Row Remapper

This block sits between a host and a row-organised non-volatile memory whose cells tolerate a limited number of writes. It turns each logical row number into a physical row number so that heavily written logical rows do not keep wearing the same physical row. The memory holds one more physical row than the host can address. That spare row, the gap, holds no live data. Two registers describe the mapping: a rotation offset (start) and the position of the gap. Rows are 4 KB each. The data path is not part of this block; only row addresses and commands pass through it.

The block counts the host writes it accepts. After every `INTERVAL` of them it moves the gap down by one row. To do this it asks the memory to copy the row just below the gap into the gap. When the gap has reached row 0, the top row is copied into row 0 instead. The gap then returns to the top and the rotation offset advances. Over many moves every logical row drifts upward by one physical position at a time. While a copy is outstanding the host port is stalled, so no access can see a row that is only partly moved. The block also puts out, as a constant, the largest number of writes one address can take before the rotation rewrites it.

Top module: `startgap_remap`

## Requirements
- R1: After reset the offset is 0 and the gap is row `ROWS`. Every logical row L maps to physical row L. `host_ready` equals `mem_ready`, and no copy is issued.
- R2: While no copy is active, `mem_paddr` = p + (p >= gap ? 1 : 0), where p = (L + start) mod `ROWS`.
- R3: A copy is issued on the cycle after exactly `INTERVAL` host writes have been accepted (`host_valid & host_ready & host_write`). Accepted reads are not counted.
- R4: A copy is presented as `mem_valid`=1 with `mem_cmd`=2'b10. The destination is on `mem_paddr` and the source is on `mem_src`. For a gap g > 0 the destination is g and the source is g-1. Both stay stable until `mem_ready` accepts the copy.
- R5: With the gap at 0, the copy has destination 0 and source `ROWS`. When it completes, the gap becomes `ROWS` and the offset becomes (start+1) mod `ROWS`. For a gap g > 0, the gap becomes g-1 on completion.
- R6: From the issue of a copy until the cycle after `mem_copy_done` is seen, `host_ready` is 0 and no host command reaches the memory.
- R7: The write count restarts at zero when a copy is issued. Copy traffic is never counted, so the next copy needs `INTERVAL` new host writes.
- R8: With no copy active, `mem_valid` follows `host_valid` and `host_ready` follows `mem_ready`. `mem_cmd` is 2'b00 for a read and 2'b01 for a write.
- R9: `vuln_writes` carries the constant `INTERVAL*(ROWS+1)`.
- R10: At every host access, the physical row selected holds the data of the requested logical row. Every copy moves live data into the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Host request accepted this cycle when high with valid |
| host_write | input | 1 | 1 = write, 0 = read |
| host_laddr | input | LAW | Logical row number, below ROWS |
| mem_valid | output | 1 | Memory command present |
| mem_ready | input | 1 | Memory accepts the command |
| mem_cmd | output | 2 | 00 read, 01 write, 10 row copy |
| mem_paddr | output | PAW | Physical row (copy destination for a copy) |
| mem_src | output | PAW | Copy source row |
| mem_copy_done | input | 1 | Pulse: the issued copy has finished |
| vuln_writes | output | 32 | Writes one address can take before it is rewritten |

## Verification
The bench keeps a shadow table that records which logical row's data sits in each physical row. It moves that data only when a copy is issued. Every host access is then checked against both the mapping formula and the shadow table. A wrong source row, a missed offset increment at the wrap or a gap that moves the wrong way would put the wrong data under the requested address. The bench counts out 127 writes with reads mixed in and checks that no copy appears. A counter that counted reads, or that kept counting through a copy, would fire early or late. Host requests are held through a copy that finishes late, so a leaky stall would let a host command reach the memory in the middle of a move. The bench also drives the gap through all positions more than once, which covers the case where the gap goes from 0 back to the top.

// File: rtl/swl_pkg.sv
// Shared types for the start-gap remapper.
// Assumes: commands are 2 bits wide, and copy is the only command the block originates.
package swl_pkg;
    typedef enum logic [1:0] {
        SWL_RD = 2'b00,
        SWL_WR = 2'b01,
        SWL_CP = 2'b10
    } swl_cmd_e;

    typedef enum logic [1:0] {
        GC_IDLE = 2'b00,
        GC_REQ  = 2'b01,
        GC_WAIT = 2'b10
    } gc_state_e;
endpackage

// File: rtl/swl_translate.sv
// Combinational logical-to-physical row translation.
// Assumes: laddr < ROWS, start < ROWS, gap <= ROWS.
module swl_translate #(
    parameter int ROWS = 8,
    localparam int LAW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int PAW = $clog2(ROWS + 1)
) (
    input  logic [LAW-1:0] laddr,
    input  logic [LAW-1:0] start,
    input  logic [PAW-1:0] gap,
    output logic [PAW-1:0] paddr
);
    logic [PAW:0] sum;
    logic [PAW:0] rot;

    // rotate by the offset modulo ROWS, then skip over the gap row
    always_comb begin
        sum = (PAW+1)'(laddr) + (PAW+1)'(start);
        rot = (sum >= (PAW+1)'(ROWS)) ? sum - (PAW+1)'(ROWS) : sum;
        paddr = (rot >= (PAW+1)'(gap)) ? PAW'(rot + 1'b1) : PAW'(rot);
    end
endmodule

// File: rtl/swl_write_counter.sv
// Counts accepted host writes and emits a one-cycle hit on every INTERVAL-th one.
// Assumes: wr_fire is only high for host writes, never for copy traffic.
module swl_write_counter #(
    parameter int INTERVAL = 128,
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_fire,
    output logic hit
);
    logic [CW-1:0] count;

    assign hit = wr_fire && (count == CW'(INTERVAL - 1));

    // advance on each counted write, restart after the interval is reached
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (hit)     count <= '0;
        else if (wr_fire) count <= count + 1'b1;
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(INTERVAL - 1));
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (count == '0));
endmodule

// File: rtl/swl_gap_ctrl.sv
// Holds the offset and gap registers and sequences one row copy per trigger.
// Assumes: trigger only arrives while idle, because the host is stalled otherwise.
module swl_gap_ctrl
    import swl_pkg::*;
#(
    parameter int ROWS = 8,
    localparam int LAW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int PAW = $clog2(ROWS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trigger,
    input  logic           mem_ready,
    input  logic           copy_done,
    output logic           busy,
    output logic           copy_req,
    output logic [LAW-1:0] start,
    output logic [PAW-1:0] gap,
    output logic [PAW-1:0] src,
    output logic [PAW-1:0] dst
);
    gc_state_e state;
    logic      finish;

    assign busy     = (state != GC_IDLE);
    assign copy_req = (state == GC_REQ);
    assign finish   = (state == GC_WAIT) && copy_done;
    assign dst      = gap;
    assign src      = (gap == '0) ? PAW'(ROWS) : gap - 1'b1;

    // copy sequencing: idle -> issue -> wait for completion
    always_ff @(posedge clk) begin
        if (!rst_n) state <= GC_IDLE;
        else begin
            case (state)
                GC_IDLE: if (trigger)   state <= GC_REQ;
                GC_REQ:  if (mem_ready) state <= GC_WAIT;
                GC_WAIT: if (copy_done) state <= GC_IDLE;
                default:                state <= GC_IDLE;
            endcase
        end
    end

    // move the gap down one row; at row 0 wrap it and advance the offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap   <= PAW'(ROWS);
            start <= '0;
        end else if (finish) begin
            if (gap == '0) begin
                gap   <= PAW'(ROWS);
                start <= (start == LAW'(ROWS - 1)) ? '0 : start + 1'b1;
            end else begin
                gap <= gap - 1'b1;
            end
        end
    end

    assert_gap_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && gap == '0) |=> (gap == PAW'(ROWS) &&
            start == (($past(start) == LAW'(ROWS - 1)) ? '0 : $past(start) + 1'b1)));
    assert_gap_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && gap != '0) |=> (gap == $past(gap) - 1'b1 && $stable(start)));
    assert_regs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> ($stable(gap) && $stable(start)));
endmodule

// File: rtl/startgap_remap.sv
// Top of the start-gap remapper: host port in, translated memory commands out.
// Assumes: the memory answers each copy with one mem_copy_done pulse after accepting it.
module startgap_remap
    import swl_pkg::*;
#(
    parameter int ROWS     = 8,
    parameter int INTERVAL = 128,
    localparam int LAW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int PAW = $clog2(ROWS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_valid,
    output logic           host_ready,
    input  logic           host_write,
    input  logic [LAW-1:0] host_laddr,
    output logic           mem_valid,
    input  logic           mem_ready,
    output logic [1:0]     mem_cmd,
    output logic [PAW-1:0] mem_paddr,
    output logic [PAW-1:0] mem_src,
    input  logic           mem_copy_done,
    output logic [31:0]    vuln_writes
);
    logic           busy, copy_req, hit, wr_fire;
    logic [LAW-1:0] start;
    logic [PAW-1:0] gap, src, dst, xlat;

    assign vuln_writes = 32'(INTERVAL * (ROWS + 1));
    assign host_ready  = !busy && mem_ready;
    assign wr_fire     = host_valid && host_ready && host_write;

    swl_translate #(.ROWS(ROWS)) u_xlat (
        .laddr(host_laddr), .start(start), .gap(gap), .paddr(xlat)
    );

    swl_write_counter #(.INTERVAL(INTERVAL)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .hit(hit)
    );

    swl_gap_ctrl #(.ROWS(ROWS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trigger(hit), .mem_ready(mem_ready),
        .copy_done(mem_copy_done), .busy(busy), .copy_req(copy_req),
        .start(start), .gap(gap), .src(src), .dst(dst)
    );

    // route either the copy or the translated host request to the memory
    always_comb begin
        mem_src = src;
        if (busy) begin
            mem_valid = copy_req;
            mem_cmd   = SWL_CP;
            mem_paddr = dst;
        end else begin
            mem_valid = host_valid;
            mem_cmd   = host_write ? SWL_WR : SWL_RD;
            mem_paddr = xlat;
        end
    end

    assert_copy_adjacent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_cmd == SWL_CP && mem_paddr != '0) |-> (mem_src == mem_paddr - 1'b1));
    assert_copy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_cmd == SWL_CP && !mem_ready) |=>
            (mem_valid && mem_cmd == SWL_CP && $stable(mem_paddr)));
    assert_stall_after_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!host_ready && mem_valid && mem_cmd == SWL_CP));
    assert_paddr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_paddr <= PAW'(ROWS)));
endmodule

// File: tb/tb_startgap_remap.sv
module tb_startgap_remap;
    localparam int ROWS = 8;
    localparam int INTERVAL = 128;
    localparam int LAW = $clog2(ROWS);
    localparam int PAW = $clog2(ROWS + 1);

    logic clk = 0, rst_n = 0;
    logic host_valid = 0, host_write = 0, mem_ready = 1, mem_copy_done = 0;
    logic [LAW-1:0] host_laddr = '0;
    logic host_ready, mem_valid;
    logic [1:0] mem_cmd;
    logic [PAW-1:0] mem_paddr, mem_src;
    logic [31:0] vuln_writes;

    int n_chk = 0, n_bad = 0;
    int m_start = 0, m_gap = ROWS, m_wcnt = 0, moves = 0;
    int shadow [0:ROWS];
    bit finished = 0;

    startgap_remap #(.ROWS(ROWS), .INTERVAL(INTERVAL)) dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_write(host_write), .host_laddr(host_laddr), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_cmd(mem_cmd), .mem_paddr(mem_paddr),
        .mem_src(mem_src), .mem_copy_done(mem_copy_done), .vuln_writes(vuln_writes)
    );

    always #5 clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_pa(int la);
        int p = (la + m_start) % ROWS;
        return (p >= m_gap) ? p + 1 : p;
    endfunction

    // one host access; checks translation and shadow data before the edge
    task automatic access(bit we, int la);
        @(negedge clk);
        host_valid = 1; host_write = we; host_laddr = LAW'(la);
        #1;
        check("R8 ready", host_ready, 1);
        check("R8 valid", mem_valid, 1);
        check("R8 cmd", mem_cmd, we ? 1 : 0);
        check("R2 paddr", mem_paddr, exp_pa(la));
        check("R10 data", shadow[mem_paddr], la);
        @(posedge clk); #1;
        host_valid = 0;
        if (we) m_wcnt++;
    endtask

    // serve the copy that must follow the INTERVAL-th write; host request held
    task automatic expect_copy(int late);
        int es = (m_gap == 0) ? ROWS : m_gap - 1;
        string tag = (m_gap == 0) ? "R5" : "R4";
        @(negedge clk);
        host_valid = 1; host_write = 1; host_laddr = '0;
        mem_ready = 0; #1;
        check({tag, " copy valid"}, mem_valid, 1);
        check({tag, " copy cmd"}, mem_cmd, 2);
        check({tag, " dst"}, mem_paddr, m_gap);
        check({tag, " src"}, mem_src, es);
        check("R6 ready low", host_ready, 0);
        @(negedge clk); mem_ready = 1; #1;
        check("R4 hold dst", mem_paddr, m_gap);
        @(posedge clk);
        shadow[m_gap] = shadow[es];
        shadow[es] = -1;
        for (int k = 0; k < late; k++) begin
            @(negedge clk); #1;
            check("R6 stall ready", host_ready, 0);
            check("R6 stall valid", mem_valid, 0);
        end
        @(negedge clk); mem_copy_done = 1; #1;
        check("R6 ready low at done", host_ready, 0);
        @(posedge clk); #1; mem_copy_done = 0;
        if (m_gap == 0) begin m_gap = ROWS; m_start = (m_start + 1) % ROWS; end
        else m_gap--;
        m_wcnt = 0; moves++;
        @(negedge clk); #1;
        check("R6 ready back", host_ready, 1);
        host_valid = 0;
    endtask

    task automatic write_maybe_move(int la, int late);
        access(1, la);
        if (m_wcnt == INTERVAL) expect_copy(late);
    endtask

    task automatic t_reset();
        for (int la = 0; la < ROWS; la++) begin
            @(negedge clk); host_valid = 1; host_write = 0; host_laddr = LAW'(la); #1;
            check("R1 identity", mem_paddr, la);
            check("R1 cmd read", mem_cmd, 0);
        end
        host_valid = 0;
        @(negedge clk); mem_ready = 0; #1;
        check("R8 ready follows mem", host_ready, 0);
        mem_ready = 1; #1;
        check("R1 ready", host_ready, 1);
        check("R9 vuln", vuln_writes, INTERVAL * (ROWS + 1));
    endtask

    task automatic t_trigger();
        for (int i = 0; i < INTERVAL - 1; i++) begin
            access(1, i % ROWS);
            access(0, (i + 3) % ROWS);
        end
        @(negedge clk); #1;
        check("R3 no early copy", mem_valid, 0);
        check("R3 no early stall", host_ready, 1);
        write_maybe_move(5, 3);
        check("R3 one move", moves, 1);
    endtask

    task automatic t_restart();
        for (int i = 0; i < INTERVAL - 1; i++) access(1, i % ROWS);
        @(negedge clk); #1;
        check("R7 count restarted", host_ready, 1);
        check("R7 no copy", mem_valid, 0);
        write_maybe_move(2, 0);
        check("R7 second move", moves, 2);
    endtask

    task automatic t_rotation();
        int target = moves + 2 * (ROWS + 1) + 1;
        int i = 0;
        while (moves < target) begin
            write_maybe_move(i % ROWS, i % 3);
            if (i % 16 == 0) access(0, (i / 16) % ROWS);
            i++;
        end
        check("R5 offset advanced", m_start, 2);
        for (int la = 0; la < ROWS; la++) access(0, la);
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) shadow[r] = r;
        shadow[ROWS] = -1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_trigger();
        t_restart();
        t_rotation();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule